// File: doc/BRIEF.md
# Low-Power Mode Controller

This block holds the operating mode of a small microcontroller core and decides when the core leaves the active medium-speed mode for one of three low-power modes (sleep, standby, watch) and when it comes back. A sleep-request pulse from the core captures three control bits: standby select, low-speed enable and the timer clock-source bit. Their combination picks the low-power target. Combinations the block does not handle raise a one-cycle direct-transfer flag and leave the mode alone.

While the core is in a low-power mode, wakeup requests from a vector of interrupt sources are filtered. Each source has its own enable bit, and a global mask blocks all of them. The current mode also limits which sources count. Standby accepts only the external IRQ0 pin and the eight wakeup pins. Watch also accepts the three timer interrupts. Sleep accepts every source. A wakeup returns the core to active medium-speed mode only when medium-speed select is 1 and low-speed enable is 0.

The block drives a one-hot mode vector, a CPU clock enable, and the registered divide ratio of the medium-speed CPU clock.

Top module: `lpm_ctrl`

## Requirements
- R1: While rst_ni is low, asynchronously and overriding everything else, mode_o is 4'b0001 (active medium-speed), cpu_clk_en_o is 1, div_ratio_o is 16 and direct_xfer_o is 0. The mode encoding is bit0 active, bit1 sleep, bit2 standby, bit3 watch, and exactly one bit is set at all times.
- R2: In active mode, a sleep request with standby select 1, low-speed enable 0 and timer clock-source 0 enters standby (4'b0100) on the next edge.
- R3: In active mode, a sleep request with standby select 1 and timer clock-source 1 enters watch (4'b1000). Low-speed enable does not matter for this case.
- R4: In active mode, a sleep request with standby select 0 and low-speed enable 0 enters sleep (4'b0010). The timer clock-source bit does not matter for this case.
- R5: In active mode, a sleep request with low-speed enable 1, and also standby select 0 or timer clock-source 0, keeps the mode and sets direct_xfer_o for exactly one cycle.
- R6: An honoured wakeup returns the mode to active only when medium-speed select is 1 and low-speed enable is 0. Otherwise the mode is kept and direct_xfer_o pulses for one cycle.
- R7: In standby, only source bit 0 (IRQ0) and bits 1 to 8 (wakeup pins) can wake the core.
- R8: In watch, bits 9 to 11 (timers) can also wake the core. In sleep, every source bit 0 to 15 can wake it.
- R9: A wakeup request has no effect while irq_mask_i is 1 or while that source's enable bit is 0.
- R10: div_ratio_o equals 16 shifted left by div_sel_i (00=16, 01=32, 10=64, 11=128). It is registered, loaded only on edges where the mode already was active, and held in the low-power modes.
- R11: cpu_clk_en_o drops to 0 on the same edge that the mode enters a low-power mode, and returns to 1 one cycle after the mode becomes active again.
- R12: A sleep request outside active mode is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sleep_req_i | input | 1 | Sleep request pulse |
| stby_sel_i | input | 1 | Standby select bit |
| lowspd_en_i | input | 1 | Low-speed enable bit |
| medspd_sel_i | input | 1 | Medium-speed select bit |
| tclk_src_i | input | 1 | Timer clock-source bit |
| div_sel_i | input | 2 | Medium-speed divide field |
| irq_req_i | input | 16 | Wakeup requests per source |
| irq_en_i | input | 16 | Per-source enable bits |
| irq_mask_i | input | 1 | Global interrupt mask |
| mode_o | output | 4 | One-hot current mode |
| cpu_clk_en_o | output | 1 | CPU clock gate enable |
| div_ratio_o | output | 8 | Medium-speed divide ratio |
| direct_xfer_o | output | 1 | Unhandled-transition pulse |

## Verification
The assertions check the following on every cycle:
- The mode stays one-hot.
- The clock enable is off whenever the mode is not active.
- The divide ratio cannot move while the core is in a low-power mode.
- The global mask always blocks wakeups.
- A direct-transfer pulse never comes with a mode change.
- A low-power mode holds when no wakeup is present.

Some behaviour depends on particular mode and source combinations, so only the bench scenarios can show it:
- The exact target chosen for each of the eight sleep-bit combinations.
- Which source bits are honoured in standby, watch and sleep.
- The one-cycle delay of the clock enable on wakeup.
- The asynchronous reset taking effect in the middle of a sleep.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  typedef enum logic [3:0] {
    MODE_ACT   = 4'b0001,
    MODE_SLP   = 4'b0010,
    MODE_STBY  = 4'b0100,
    MODE_WATCH = 4'b1000
  } mode_e;

  typedef enum logic [1:0] {
    TGT_SLP,
    TGT_STBY,
    TGT_WATCH,
    TGT_XFER
  } sleep_tgt_e;
endpackage

// File: rtl/lpm_sleep_decode.sv
module lpm_sleep_decode
  import lpm_pkg::*;
(
  input  logic       stby_sel_i,
  input  logic       lowspd_en_i,
  input  logic       tclk_src_i,
  output sleep_tgt_e tgt_o
);
  always_comb begin
    if (stby_sel_i && tclk_src_i)        tgt_o = TGT_WATCH;
    else if (stby_sel_i && !lowspd_en_i) tgt_o = TGT_STBY;
    else if (!stby_sel_i && !lowspd_en_i) tgt_o = TGT_SLP;
    else                                  tgt_o = TGT_XFER;
  end
endmodule

// File: rtl/lpm_wake_filter.sv
module lpm_wake_filter
  import lpm_pkg::*;
#(
  parameter int NUM_SRC  = 16,
  parameter int IRQ0_BIT = 0,
  parameter int WKP_LO   = 1,
  parameter int WKP_N    = 8,
  parameter int TMR_LO   = 9,
  parameter int TMR_N    = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  mode_e              mode_i,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic [NUM_SRC-1:0] en_i,
  input  logic               mask_i,
  output logic               wake_o
);
  localparam int WKP_HI = WKP_LO + WKP_N;
  localparam int TMR_HI = TMR_LO + TMR_N;

  logic [NUM_SRC-1:0] stby_allow, watch_allow, allow, live;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_allow
    assign stby_allow[i]  = (i == IRQ0_BIT) || (i >= WKP_LO && i < WKP_HI);
    assign watch_allow[i] = stby_allow[i] || (i >= TMR_LO && i < TMR_HI);
  end

  always_comb begin
    unique case (mode_i)
      MODE_STBY:  allow = stby_allow;
      MODE_WATCH: allow = watch_allow;
      MODE_SLP:   allow = '1;
      default:    allow = '0;
    endcase
  end

  assign live   = req_i & en_i & allow;
  assign wake_o = !mask_i && (|live);

  AST_MASK_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_i |-> !wake_o); // R9
  AST_NO_WAKE_ACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_ACT) |-> !wake_o); // R12
endmodule

// File: rtl/lpm_clk_ctrl.sv
module lpm_clk_ctrl
  import lpm_pkg::*;
#(
  parameter int DIV_SEL_W     = 2,
  parameter int BASE_DIV_LOG2 = 4,
  parameter int DIV_W         = BASE_DIV_LOG2 + (1 << DIV_SEL_W)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  mode_e                mode_q_i,
  input  mode_e                mode_d_i,
  input  logic [DIV_SEL_W-1:0] div_sel_i,
  output logic                 clk_en_o,
  output logic [DIV_W-1:0]     div_ratio_o
);
  localparam logic [DIV_W-1:0] DIV_RST = DIV_W'(1) << BASE_DIV_LOG2;

  logic             clk_en_q;
  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_en_q <= 1'b1;
      div_q    <= DIV_RST;
    end else begin
      // re-enable only once the mode was already active for a cycle
      clk_en_q <= (mode_d_i == MODE_ACT) && (mode_q_i == MODE_ACT);
      if (mode_q_i == MODE_ACT) div_q <= DIV_RST << div_sel_i;
    end
  end

  assign clk_en_o    = clk_en_q;
  assign div_ratio_o = div_q;

  AST_DIV_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q_i != MODE_ACT) |=> $stable(div_q)); // R10
  AST_CLKEN_LOWPWR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q_i != MODE_ACT) |-> !clk_en_q); // R11
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int NUM_SRC   = 16,
  parameter int DIV_SEL_W = 2,
  parameter int BASE_LOG2 = 4,
  localparam int DIV_W    = BASE_LOG2 + (1 << DIV_SEL_W)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sleep_req_i,
  input  logic                 stby_sel_i,
  input  logic                 lowspd_en_i,
  input  logic                 medspd_sel_i,
  input  logic                 tclk_src_i,
  input  logic [DIV_SEL_W-1:0] div_sel_i,
  input  logic [NUM_SRC-1:0]   irq_req_i,
  input  logic [NUM_SRC-1:0]   irq_en_i,
  input  logic                 irq_mask_i,
  output logic [3:0]           mode_o,
  output logic                 cpu_clk_en_o,
  output logic [DIV_W-1:0]     div_ratio_o,
  output logic                 direct_xfer_o
);
  mode_e      mode_q, mode_d;
  sleep_tgt_e tgt;
  logic       wake, xfer_q, xfer_d;

  lpm_sleep_decode u_dec (
    .stby_sel_i (stby_sel_i),
    .lowspd_en_i(lowspd_en_i),
    .tclk_src_i (tclk_src_i),
    .tgt_o      (tgt)
  );

  lpm_wake_filter #(.NUM_SRC(NUM_SRC)) u_wake (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .mode_i(mode_q),
    .req_i (irq_req_i),
    .en_i  (irq_en_i),
    .mask_i(irq_mask_i),
    .wake_o(wake)
  );

  lpm_clk_ctrl #(.DIV_SEL_W(DIV_SEL_W), .BASE_DIV_LOG2(BASE_LOG2)) u_clk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_q_i   (mode_q),
    .mode_d_i   (mode_d),
    .div_sel_i  (div_sel_i),
    .clk_en_o   (cpu_clk_en_o),
    .div_ratio_o(div_ratio_o)
  );

  always_comb begin
    mode_d = mode_q;
    xfer_d = 1'b0;
    if (mode_q == MODE_ACT) begin
      if (sleep_req_i) begin
        unique case (tgt)
          TGT_SLP:   mode_d = MODE_SLP;
          TGT_STBY:  mode_d = MODE_STBY;
          TGT_WATCH: mode_d = MODE_WATCH;
          default:   xfer_d = 1'b1;
        endcase
      end
    end else if (wake) begin
      if (medspd_sel_i && !lowspd_en_i) mode_d = MODE_ACT;
      else                              xfer_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_ACT;
      xfer_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      xfer_q <= xfer_d;
    end
  end

  assign mode_o        = mode_q;
  assign direct_xfer_o = xfer_q;

  AST_MODE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(mode_q)); // R1
  AST_XFER_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_q |-> (mode_q == $past(mode_q))); // R5
  AST_LP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_q != MODE_ACT) && !wake) |=> $stable(mode_q)); // R12
endmodule

// File: tb/tb_lpm_ctrl.sv
module tb_lpm_ctrl;
  localparam logic [3:0] M_ACT = 4'b0001, M_SLP = 4'b0010,
                         M_STB = 4'b0100, M_WAT = 4'b1000;
  // {stby, lowspd, tclk, exp_xfer, exp_mode[3:0]}
  localparam logic [7:0] VEC [8] = '{
    8'b000_0_0010, 8'b001_0_0010, 8'b010_1_0001, 8'b011_1_0001,
    8'b100_0_0100, 8'b101_0_1000, 8'b110_1_0001, 8'b111_0_1000
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic sleep_req = 0, stby = 0, ls = 0, med = 1, tclk = 0, mask = 0;
  logic [1:0]  div_sel = 0;
  logic [15:0] req = 0, en = '1;
  logic [3:0]  mode;
  logic        clk_en, xfer;
  logic [7:0]  div;
  int total = 0, fails = 0;

  always #2 clk = ~clk;

  lpm_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .sleep_req_i(sleep_req), .stby_sel_i(stby),
    .lowspd_en_i(ls), .medspd_sel_i(med), .tclk_src_i(tclk), .div_sel_i(div_sel),
    .irq_req_i(req), .irq_en_i(en), .irq_mask_i(mask), .mode_o(mode),
    .cpu_clk_en_o(clk_en), .div_ratio_o(div), .direct_xfer_o(xfer)
  );

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 0; sleep_req = 0; req = 0; ls = 0; med = 1; mask = 0; en = '1; div_sel = 0;
    @(negedge clk); @(negedge clk);
    rst_ni = 1;
  endtask

  task automatic enter(logic s, logic l, logic t);
    stby = s; ls = l; tclk = t; sleep_req = 1;
    @(negedge clk);
    sleep_req = 0; ls = 0;
  endtask

  task automatic pulse(int b);
    req = 16'(1) << b;
    @(negedge clk);
    req = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    // sleep decode table
    for (int i = 0; i < 8; i++) begin
      do_reset();
      enter(VEC[i][7], VEC[i][6], VEC[i][5]);
      chk("R2/R3/R4/R5 mode", 32'(mode), 32'(VEC[i][3:0]));
      chk("R5 xfer", 32'(xfer), 32'(VEC[i][4]));
      chk("R11 clk_en", 32'(clk_en), 32'(VEC[i][3:0] == M_ACT));
      @(negedge clk);
      chk("R5 xfer one cycle", 32'(xfer), 0);
    end

    do_reset();
    chk("R1 mode", 32'(mode), 32'(M_ACT));
    chk("R1 clk_en", 32'(clk_en), 1);
    chk("R1 div", 32'(div), 16);
    chk("R1 xfer", 32'(xfer), 0);
    div_sel = 2;
    @(negedge clk);
    chk("R10 div 64", 32'(div), 64);

    enter(1, 0, 0);
    chk("R2 stby", 32'(mode), 32'(M_STB));
    chk("R11 off", 32'(clk_en), 0);
    div_sel = 3;
    pulse(9);
    chk("R7 timer ignored", 32'(mode), 32'(M_STB));
    chk("R10 div held", 32'(div), 64);
    pulse(13);
    chk("R7 other ignored", 32'(mode), 32'(M_STB));
    pulse(5);
    chk("R7 wkp wakes", 32'(mode), 32'(M_ACT));
    chk("R11 still off", 32'(clk_en), 0);
    chk("R10 not yet", 32'(div), 64);
    @(negedge clk);
    chk("R11 back on", 32'(clk_en), 1);
    chk("R10 div 128", 32'(div), 128);

    enter(1, 0, 0);
    pulse(0);
    chk("R7 irq0 wakes", 32'(mode), 32'(M_ACT));

    enter(1, 1, 1);
    chk("R3 watch", 32'(mode), 32'(M_WAT));
    pulse(12);
    chk("R8 watch ignores 12", 32'(mode), 32'(M_WAT));
    pulse(10);
    chk("R8 timer wakes", 32'(mode), 32'(M_ACT));

    enter(0, 0, 1);
    chk("R4 sleep", 32'(mode), 32'(M_SLP));
    enter(1, 0, 1);
    chk("R12 req ignored", 32'(mode), 32'(M_SLP));
    mask = 1;
    pulse(15);
    chk("R9 mask", 32'(mode), 32'(M_SLP));
    mask = 0; en = ~(16'(1) << 15);
    pulse(15);
    chk("R9 enable", 32'(mode), 32'(M_SLP));
    en = '1; med = 0;
    pulse(15);
    chk("R6 held", 32'(mode), 32'(M_SLP));
    chk("R6 xfer", 32'(xfer), 1);
    med = 1;
    @(negedge clk);
    chk("R6 xfer clear", 32'(xfer), 0);
    ls = 1;
    pulse(15);
    chk("R6 ls held", 32'(mode), 32'(M_SLP));
    ls = 0;
    pulse(15);
    chk("R8 any wakes sleep", 32'(mode), 32'(M_ACT));

    enter(0, 0, 0);
    #1 rst_ni = 0;
    #1;
    chk("R1 async mode", 32'(mode), 32'(M_ACT));
    chk("R1 async clk_en", 32'(clk_en), 1);
    @(negedge clk);
    rst_ni = 1;

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule